// File: doc/BRIEF.md
# Weighted Priority Channel Service Scheduler

This block chooses which of sixteen timer channels is given to a single shared execution engine. Each channel can raise a request from four independent sources: a host request, a link from another channel, a match event and a capture event. Any asserted source marks the channel as pending. The mark stays until the engine reports that it has finished serving that channel.

Every channel carries a 2-bit priority code. One code value switches the channel off, and the other three place it in the low, middle or high level. The scheduler steps through a fixed cycle of seven time slots. Within each cycle, high priority owns four slots, middle owns two and low owns one, so the upper levels get more service without locking out the lower ones.

Within one level, channels are served in passes. A pass is a snapshot of the level's pending channels. It is served lowest number first and then in ascending order before any channel of the pass can be served again. Only one grant is outstanding at a time. The engine ends it by pulsing a done input.

Top module: `svc_sched`

## Requirements
- R1: Priority code 00 disables a channel. A disabled channel is never granted, and a request that arrives while its code is 00 is not latched. Enabling the channel afterwards therefore produces no grant.
- R2: A pulse on any one of the four request sources of an enabled channel marks it pending. The mark holds until the grant for that channel ends with done.
- R3: The scheduled level follows the repeating slot sequence high, middle, high, low, high, middle, high. After reset the sequence starts at its first slot, and it moves one slot forward with every grant issued and at no other time. Codes are 11 high, 10 middle and 01 low.
- R4: If the scheduled level has no eligible pending channel, the grant goes to the first non-empty level in the order high, middle, low. The slot still moves forward.
- R5: Within a level, the lowest-numbered channel of the current pass is granted first. The remaining channels of that pass follow in ascending order before a new pass starts.
- R6: A pass is taken as a snapshot of the level's eligible pending channels when the pass starts. A request arriving during the pass, including one from a channel the pass has already served, waits for the next pass.
- R7: At most one grant is outstanding. In the cycle after done is sampled with a grant active, the grant-valid output is low. A done pulse while no grant is active has no effect.
- R8: While a grant is active, the granted channel number stays unchanged. The grant-valid output stays low while no enabled channel is pending. After reset, grant-valid and the channel number are both 0.
- R9: When no grant is active and an enabled channel is pending, a grant is issued at the next clock edge. A request pulse sampled at one edge therefore shows up as a grant after the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | NCH | Host service request, one bit per channel |
| link_req | input | NCH | Link request from another channel, one bit per channel |
| match_evt | input | NCH | Match event request, one bit per channel |
| capt_evt | input | NCH | Capture event request, one bit per channel |
| prio | input | 2*NCH | Priority code of channel i in bits [2i+1:2i]: 00 off, 01 low, 10 middle, 11 high |
| done | input | 1 | Engine finished the current grant (one-cycle pulse) |
| gnt_vld | output | 1 | A grant is active |
| gnt_ch | output | CHW | Number of the granted channel |

## Verification
Several properties are checked on every cycle. A newly issued grant always names an enabled channel that is pending. The channel number holds for the whole service. Grant-valid drops after done, and a grant follows promptly once an enabled request is waiting. The slot pointer moves only when a grant is issued. Only the bench scenarios can show which channel is granted in which order: the slot weighting, the fall-through between levels, the ascending passes, and the deferral of requests that arrive during a pass. The bench drives many priority mixes to exercise these cases.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NLVL  = 3;
  localparam int NSLOT = 7;

  // level code of a slot: even slots high, slot 3 low, others middle
  function automatic logic [1:0] slot_level(input logic [2:0] s);
    if (!s[0])        return 2'd3;
    else if (s == 3'd3) return 2'd1;
    else              return 2'd2;
  endfunction

  function automatic logic [2:0] slot_next(input logic [2:0] s);
    return (s == 3'(NSLOT - 1)) ? 3'd0 : s + 3'd1;
  endfunction

  // picks a level index (0 low .. 2 high) given wanted code and non-empty levels
  function automatic logic [1:0] pick_level(input logic [1:0] want_code,
                                            input logic [NLVL-1:0] has);
    logic [1:0] w;
    w = want_code - 2'd1;
    if (has[w])      return w;
    else if (has[2]) return 2'd2;
    else if (has[1]) return 2'd1;
    else             return 2'd0;
  endfunction
endpackage

// File: rtl/sched_pend.sv
module sched_pend #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] src_any,
  input  logic [NCH-1:0] enab,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | (src_any & enab);
  end
endmodule

// File: rtl/sched_slot.sv
module sched_slot
  import sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [2:0] slot_q,
  output logic [1:0] want_code
);
  always_ff @(posedge clk) begin
    if (!rst_n)   slot_q <= 3'd0;
    else if (adv) slot_q <= slot_next(slot_q);
  end

  assign want_code = slot_level(slot_q);
endmodule

// File: rtl/sched_lvl_pick.sv
module sched_lvl_pick #(
  parameter int NCH = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  input  logic           take,
  output logic           has_req,
  output logic [CHW-1:0] pick_ch
);
  logic [NCH-1:0] pass_q;
  logic [NCH-1:0] live;
  logic [NCH-1:0] cand;
  logic [NCH-1:0] pick_oh;
  logic           found;

  assign live    = pass_q & elig;
  assign cand    = (|live) ? live : elig;
  assign has_req = |elig;

  always_comb begin
    pick_oh = '0;
    pick_ch = '0;
    found   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (cand[i] && !found) begin
        pick_oh[i] = 1'b1;
        pick_ch    = CHW'(i);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pass_q <= '0;
    else if (take) pass_q <= cand & ~pick_oh;
  end
endmodule

// File: rtl/svc_sched.sv
module svc_sched
  import sched_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   host_req,
  input  logic [NCH-1:0]   link_req,
  input  logic [NCH-1:0]   match_evt,
  input  logic [NCH-1:0]   capt_evt,
  input  logic [2*NCH-1:0] prio,
  input  logic             done,
  output logic             gnt_vld,
  output logic [CHW-1:0]   gnt_ch
);
  logic [NCH-1:0]  enab;
  logic [NCH-1:0]  src_any;
  logic [NCH-1:0]  pend_q;
  logic [NCH-1:0]  elig;
  logic [NCH-1:0]  clr;
  logic [NCH-1:0]  lvl_elig [NLVL];
  logic [NLVL-1:0] lvl_has;
  logic [NLVL-1:0] lvl_take;
  logic [CHW-1:0]  lvl_ch [NLVL];
  logic [2:0]      slot_q;
  logic [1:0]      want_code;
  logic [1:0]      sel_lvl;
  logic            issue_w;
  logic            finish_w;

  assign src_any = host_req | link_req | match_evt | capt_evt;

  always_comb begin
    for (int i = 0; i < NCH; i++) enab[i] = |prio[2*i +: 2];
  end

  assign elig = pend_q & enab;

  always_comb begin
    for (int l = 0; l < NLVL; l++) begin
      for (int i = 0; i < NCH; i++)
        lvl_elig[l][i] = pend_q[i] && (prio[2*i +: 2] == 2'(l + 1));
    end
  end

  assign issue_w  = !gnt_vld && (|elig);
  assign finish_w = gnt_vld && done;
  assign sel_lvl  = pick_level(want_code, lvl_has);

  always_comb begin
    clr = '0;
    if (finish_w) clr[gnt_ch] = 1'b1;
  end

  sched_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_any(src_any), .enab(enab),
    .clr(clr), .pend_q(pend_q)
  );

  sched_slot u_slot (
    .clk(clk), .rst_n(rst_n), .adv(issue_w),
    .slot_q(slot_q), .want_code(want_code)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    assign lvl_take[l] = issue_w && (sel_lvl == 2'(l));
    sched_lvl_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
      .clk(clk), .rst_n(rst_n), .elig(lvl_elig[l]), .take(lvl_take[l]),
      .has_req(lvl_has[l]), .pick_ch(lvl_ch[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_vld <= 1'b0;
      gnt_ch  <= '0;
    end else if (issue_w) begin
      gnt_vld <= 1'b1;
      gnt_ch  <= lvl_ch[sel_lvl];
    end else if (finish_w) begin
      gnt_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/svc_sched_chk.sv
module svc_sched_chk #(
  parameter int NCH = 16,
  parameter int CHW = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2*NCH-1:0] prio,
  input logic             done,
  input logic             gnt_vld,
  input logic [CHW-1:0]   gnt_ch,
  input logic [NCH-1:0]   pend_q,
  input logic [NCH-1:0]   elig,
  input logic [2:0]       slot_q,
  input logic             issue_w
);
  AST_GNT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_vld) |-> (prio[2*gnt_ch +: 2] != 2'b00)); // R1
  AST_GNT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> pend_q[gnt_ch]); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_w |=> $stable(slot_q)); // R3
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && done) |=> !gnt_vld); // R7
  AST_GNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !done) |=> (gnt_vld && $stable(gnt_ch))); // R8
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && !(|elig)) |=> !gnt_vld); // R8
  AST_PROMPT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && (|elig)) |=> gnt_vld); // R9
endmodule

bind svc_sched svc_sched_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prio(prio), .done(done), .gnt_vld(gnt_vld),
  .gnt_ch(gnt_ch), .pend_q(pend_q), .elig(elig), .slot_q(slot_q),
  .issue_w(issue_w)
);

// File: tb/sim_svc_sched.sv
module sim_svc_sched;
  localparam int CLK_T = 10;
  localparam int NCH   = 16;
  localparam int CHW   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   host_req = '0, link_req = '0, match_evt = '0, capt_evt = '0;
  logic [2*NCH-1:0] prio;
  logic             done = 1'b0;
  logic             gnt_vld;
  logic [CHW-1:0]   gnt_ch;

  int checks = 0;
  int errors = 0;

  // bench model state
  int         mp [NCH];
  logic [15:0] m_pend = '0;
  logic [15:0] m_pass [3];
  int         m_slot = 0;

  always #(CLK_T/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) prio[2*i +: 2] = 2'(mp[i]);
  end

  svc_sched #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .link_req(link_req),
    .match_evt(match_evt), .capt_evt(capt_evt), .prio(prio), .done(done),
    .gnt_vld(gnt_vld), .gnt_ch(gnt_ch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_of(input int s);
    if (s % 2 == 0) return 3;
    if (s == 3) return 1;
    return 2;
  endfunction

  function automatic int model_elig_count();
    int n = 0;
    for (int i = 0; i < NCH; i++) if (m_pend[i] && mp[i] != 0) n++;
    return n;
  endfunction

  task automatic model_issue(output int ch);
    logic [15:0] el [3];
    logic [15:0] c;
    int want, lv;
    for (int l = 0; l < 3; l++) begin
      el[l] = '0;
      for (int i = 0; i < NCH; i++) if (m_pend[i] && mp[i] == l + 1) el[l][i] = 1'b1;
    end
    want = lvl_of(m_slot) - 1;
    if (el[want] != 0) lv = want;
    else if (el[2] != 0) lv = 2;
    else if (el[1] != 0) lv = 1;
    else lv = 0;
    c = m_pass[lv] & el[lv];
    if (c == 0) c = el[lv];
    ch = -1;
    for (int i = 0; i < NCH; i++) if (c[i] && ch < 0) ch = i;
    if (ch >= 0) c[ch] = 1'b0;
    m_pass[lv] = c;
    m_slot = (m_slot + 1) % 7;
  endtask

  // called at a negedge, returns at the next negedge
  task automatic pulse_req(input logic [15:0] mask, input int srcsel);
    for (int i = 0; i < NCH; i++) begin
      if (mask[i]) begin
        case ((i + srcsel) % 4)
          0: host_req[i]  = 1'b1;
          1: link_req[i]  = 1'b1;
          2: match_evt[i] = 1'b1;
          default: capt_evt[i] = 1'b1;
        endcase
        if (mp[i] != 0) m_pend[i] = 1'b1;
      end
    end
    @(negedge clk);
    host_req = '0; link_req = '0; match_evt = '0; capt_evt = '0;
  endtask

  task automatic serve_one(input bit inject, input logic [15:0] inj_mask, output int got);
    int n = 0;
    int e;
    int hold;
    got = -1;
    while (!gnt_vld && n < 20) begin @(negedge clk); n++; end
    if (!gnt_vld) begin
      chk(1'b0, "R9 grant missing", 0, 1);
      return;
    end
    model_issue(e);
    chk(int'(gnt_ch) == e, "R3 R4 R5 R6 order", int'(gnt_ch), e);
    hold = int'(gnt_ch);
    got = hold;
    if (inject) pulse_req(inj_mask, 1);
    else @(negedge clk);
    chk(gnt_vld && int'(gnt_ch) == hold, "R8 hold", int'(gnt_ch), hold);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    if (e >= 0) m_pend[e] = 1'b0;
    chk(!gnt_vld, "R7 gap", int'(gnt_vld), 0);
  endtask

  task automatic drain(input int inject_at);
    int k = 0;
    int first = 0;
    int got;
    while (model_elig_count() > 0 && k < 64) begin
      serve_one(k == inject_at, 16'(1) << first, got);
      if (k == 0 && got >= 0) first = got;
      k++;
    end
    repeat (4) @(negedge clk);
    chk(!gnt_vld, "R8 idle", int'(gnt_vld), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got;
    for (int l = 0; l < 3; l++) m_pass[l] = '0;
    for (int i = 0; i < NCH; i++) mp[i] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt_vld == 1'b0, "R8 reset valid", int'(gnt_vld), 0);
    chk(gnt_ch == '0, "R8 reset channel", int'(gnt_ch), 0);

    // R9: latency of one request
    pulse_req(16'h0020, 0);
    chk(!gnt_vld, "R9 not yet", int'(gnt_vld), 0);
    @(negedge clk);
    chk(gnt_vld && gnt_ch == 4'd5, "R9 latency", int'(gnt_ch), 5);
    serve_one(1'b0, '0, got);

    // R1: disabled channel request dropped
    mp[3] = 0;
    pulse_req(16'h0008, 2);
    repeat (4) @(negedge clk);
    chk(!gnt_vld, "R1 disabled", int'(gnt_vld), 0);
    mp[3] = 1;
    repeat (4) @(negedge clk);
    chk(!gnt_vld, "R1 not latched", int'(gnt_vld), 0);

    // R7: done while idle ignored
    done = 1'b1; @(negedge clk); done = 1'b0;
    @(negedge clk);
    chk(!gnt_vld, "R7 idle done", int'(gnt_vld), 0);

    // R2 R3 R4 R5 R6: sweep priority mixes, all channels request
    for (int cfg = 0; cfg < 12; cfg++) begin
      for (int i = 0; i < NCH; i++) begin
        if (cfg == 0) mp[i] = 3;
        else if (cfg == 1) mp[i] = 1;
        else if (cfg == 2) mp[i] = (i < 2) ? 1 : 2;
        else mp[i] = (i * cfg + cfg / 2) % 4;
      end
      @(negedge clk);
      pulse_req(16'hFFFF, cfg);
      drain(2 + (cfg % 3));
    end

    // R2: partial request sets through single sources
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < NCH; i++) mp[i] = 1 + ((i + s) % 3);
      pulse_req(16'hA5A5 >> s, s);
      drain(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule